// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the control path of an audio codec. A CPU reaches sixteen eight-bit indirect registers through a two-step access. It first writes an index byte, and then reads or writes a data port. A status port carries the codec interrupt flag next to seven flag bits supplied by the sample data path. The index byte also holds three controls: a read-only busy flag while the codec initializes, a mode-change enable that unlocks the format and interface settings, and a transfer-request disable.

A hidden 16-bit down-counter measures out blocks of samples. Software writes the low byte of the block length and then the high byte. The high-byte write loads the counter. While playback or capture is enabled and no mode change is in progress, each sample strobe counts the counter down. The strobe that finds it at zero raises the interrupt status and reloads the counter. Gain, attenuation and mute settings are only stored here, for the analog side to use.

Top module: `codec_rf_top`

## Requirements
- R1: After reset, the indirect registers read: 00h at indexes 0-1, 80h at indexes 2-7, 00h at index 8, 10h at index 9 and 08h at index 12, and 00h at every other index. The index port reads 40h with the busy input low, which means mode-change enable is set. Port offsets: 0 = index, 1 = data, 2 = status, 3 = reads 00h and ignores writes.
- R2: Index port layout: bit 7 shows the init-busy input (read-only), bit 6 is mode-change enable, bit 5 is transfer disable, bit 4 reads 0, and bits 3:0 select the indirect register.
- R3: While init-busy is high, data-port writes change nothing and data-port reads return 80h.
- R4: Index 8 (data format) takes writes only while mode-change enable is set. Other writes to it leave it unchanged.
- R5: At index 9 (interface configuration), bits 7:2 change only while mode-change enable is set. Bits 1:0 are always writable. Bit 0 is playback enable, bit 1 is capture enable, bit 6 is playback PIO mode and bit 7 is capture PIO mode.
- R6: Bits 3:0 of index 12 always read 8h. Bits 7:4 are writable.
- R7: A write to index 14 (count high byte) loads the hidden counter with {written byte, index 15}. A write to index 15 alone does not load it.
- R8: When bit 0 or bit 1 of index 9 is set, each sample strobe decrements the counter. A strobe that finds the counter at 0 instead sets the interrupt status and reloads the counter from {index 14, index 15}. With a base of N, the interrupt appears on strobe N+1 after the load. Strobes are ignored when both enables are clear.
- R9: While mode-change enable is set, sample strobes are ignored.
- R10: Status port bit 0 is the interrupt status and bits 7:1 show the data-path flags. Any status write clears bit 0.
- R11: The interrupt output equals the interrupt status only while bit 1 of index 10 is set. Otherwise it is 0.
- R12: The transfer request is high when transfer disable is clear and either playback is pending with playback enabled and in DMA mode, or capture is pending with capture enabled and in DMA mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed port |
| bus_addr | input | 2 | Port offset within the codec window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed port (combinational) |
| init_busy | input | 1 | Codec initialization in progress |
| sample_stb | input | 1 | One pulse per processed sample |
| dp_flags | input | 7 | Data-path flags shown in status bits 7:1 |
| play_pend | input | 1 | Playback sample waiting for transfer |
| cap_pend | input | 1 | Capture sample waiting for transfer |
| irq_out | output | 1 | Codec interrupt pin |
| xfer_req | output | 1 | DMA transfer request |

## Verification
Directed sequences set a small block length and count strobes one at a time. This separates an interrupt raised one strobe early from the correct one on strobe N+1, and shows that the reload repeats the period. The strobe is also applied with both enables clear and with mode change set, to show that the counter stays frozen. Random traffic then mixes index, data and status accesses with busy toggling and random lock states. Each data read is compared with a bench model. This tells apart the locked fields from the free fields at indexes 8, 9 and 12, and shows the busy read value differs from the stored contents. Random pending inputs sweep every combination of disable, enable and transfer mode for the request output.

// File: rtl/codec_rf_pkg.sv
package codec_rf_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_IDX = 16;
    localparam int IDX_W   = $clog2(NUM_IDX);
    localparam int CNT_W   = 2 * REG_W;
    localparam int FLAG_W  = REG_W - 1;

    typedef enum logic [1:0] {
        PORT_INDEX  = 2'd0,
        PORT_DATA   = 2'd1,
        PORT_STATUS = 2'd2,
        PORT_NONE   = 2'd3
    } port_e;

    localparam logic [IDX_W-1:0] IX_FORMAT = IDX_W'(8);
    localparam logic [IDX_W-1:0] IX_IFACE  = IDX_W'(9);
    localparam logic [IDX_W-1:0] IX_PINCTL = IDX_W'(10);
    localparam logic [IDX_W-1:0] IX_MISC   = IDX_W'(12);
    localparam logic [IDX_W-1:0] IX_CNT_HI = IDX_W'(14);
    localparam logic [IDX_W-1:0] IX_CNT_LO = IDX_W'(15);

    localparam logic [REG_W-1:0] BUSY_READ = REG_W'(8'h80);

    typedef struct packed {
        logic             mce;
        logic             tdis;
        logic [IDX_W-1:0] sel;
    } index_t;

    typedef struct packed {
        logic cap_pio;
        logic play_pio;
        logic cap_en;
        logic play_en;
    } xfer_cfg_t;

    function automatic logic [REG_W-1:0] reset_value(input int unsigned ix);
        logic [REG_W-1:0] v;
        if (ix >= 2 && ix <= 7)              v = REG_W'(8'h80);
        else if (ix == int'(IX_IFACE))       v = REG_W'(8'h10);
        else if (ix == int'(IX_MISC))        v = REG_W'(8'h08);
        else                                 v = '0;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] write_mask(input int unsigned ix, input logic mce);
        logic [REG_W-1:0] m;
        if (ix == int'(IX_FORMAT))           m = mce ? '1 : '0;
        else if (ix == int'(IX_IFACE))       m = mce ? '1 : REG_W'(8'h03);
        else if (ix == int'(IX_MISC))        m = REG_W'(8'hF0);
        else                                 m = '1;
        return m;
    endfunction
endpackage

// File: rtl/codec_rf_bank.sv
module codec_rf_bank
    import codec_rf_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_sel,
    input  logic [REG_W-1:0]                  wr_data,
    input  logic                              mce,
    output logic [NUM_IDX-1:0][REG_W-1:0]     regs
);
    for (genvar i = 0; i < NUM_IDX; i++) begin : g_reg
        logic [REG_W-1:0] mask;
        logic             hit;
        assign mask = write_mask(i, mce);
        assign hit  = wr_en && (wr_sel == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst)      regs[i] <= reset_value(i);
            else if (hit) regs[i] <= (regs[i] & ~mask) | (wr_data & mask);
        end
    end

    // R4: format register frozen when a write arrives without mode change
    a_r4_fmt_lock: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mce) |=> $stable(regs[IX_FORMAT]));

    // R5: upper interface bits frozen without mode change
    a_r5_iface_lock: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mce) |=> $stable(regs[IX_IFACE][REG_W-1:2]));

    // R6: misc low nibble constant after any write
    a_r6_misc_ro: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (regs[IX_MISC][3:0] == 4'h8));
endmodule

// File: rtl/codec_rf_counter.sv
module codec_rf_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] base,
    input  logic          stb,
    input  logic          run,
    input  logic          clr,
    output logic          irq_stat
);
    logic [CW-1:0] cur;
    logic          tick;
    logic          at_zero;
    logic          set_now;

    assign tick    = stb && run && !load;
    assign at_zero = (cur == '0);
    assign set_now = tick && at_zero;

    always_ff @(posedge clk) begin
        if (rst)          cur <= '0;
        else if (load)    cur <= load_val;
        else if (tick)    cur <= at_zero ? base : cur - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)          irq_stat <= 1'b0;
        else if (set_now) irq_stat <= 1'b1;
        else if (clr)     irq_stat <= 1'b0;
    end

    // R8: counting from zero reloads the base value
    a_r8_reload: assert property (@(posedge clk) disable iff (rst)
        (stb && run && !load && cur == '0) |=> (cur == $past(base)));

    // R8: counting from zero raises the interrupt status
    a_r8_irq_set: assert property (@(posedge clk) disable iff (rst)
        (stb && run && !load && cur == '0) |=> irq_stat);

    // R9: counter holds while not running and not loaded
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cur));

    // R7: a load places the given value in the counter
    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur == $past(load_val)));

    // R10: a clear without a simultaneous set drops the status
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !(stb && run && !load && cur == '0)) |=> !irq_stat);
endmodule

// File: rtl/codec_rf_top.sv
module codec_rf_top
    import codec_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              init_busy,
    input  logic              sample_stb,
    input  logic [FLAG_W-1:0] dp_flags,
    input  logic              play_pend,
    input  logic              cap_pend,
    output logic              irq_out,
    output logic              xfer_req
);
    index_t                          idx;
    logic [NUM_IDX-1:0][REG_W-1:0]   regs;
    port_e                           port;
    logic                            data_wr;
    logic                            stat_wr;
    logic                            cnt_load;
    logic                            irq_stat;
    logic                            run;
    xfer_cfg_t                       xcfg;

    assign port     = port_e'(bus_addr);
    assign data_wr  = bus_we && (port == PORT_DATA) && !init_busy;
    assign stat_wr  = bus_we && (port == PORT_STATUS);
    assign cnt_load = data_wr && (idx.sel == IX_CNT_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx.mce  <= 1'b1;
            idx.tdis <= 1'b0;
            idx.sel  <= '0;
        end else if (bus_we && port == PORT_INDEX) begin
            idx.mce  <= bus_wdata[6];
            idx.tdis <= bus_wdata[5];
            idx.sel  <= bus_wdata[IDX_W-1:0];
        end
    end

    codec_rf_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (data_wr),
        .wr_sel  (idx.sel),
        .wr_data (bus_wdata),
        .mce     (idx.mce),
        .regs    (regs)
    );

    assign xcfg = '{cap_pio:  regs[IX_IFACE][7],
                    play_pio: regs[IX_IFACE][6],
                    cap_en:   regs[IX_IFACE][1],
                    play_en:  regs[IX_IFACE][0]};
    assign run  = (xcfg.play_en || xcfg.cap_en) && !idx.mce;

    codec_rf_counter #(.CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val ({bus_wdata, regs[IX_CNT_LO]}),
        .base     ({regs[IX_CNT_HI], regs[IX_CNT_LO]}),
        .stb      (sample_stb),
        .run      (run),
        .clr      (stat_wr),
        .irq_stat (irq_stat)
    );

    always_comb begin
        unique case (port)
            PORT_INDEX:  bus_rdata = {init_busy, idx.mce, idx.tdis, 1'b0, idx.sel};
            PORT_DATA:   bus_rdata = init_busy ? BUSY_READ : regs[idx.sel];
            PORT_STATUS: bus_rdata = {dp_flags, irq_stat};
            default:     bus_rdata = '0;
        endcase
    end

    assign irq_out  = irq_stat && regs[IX_PINCTL][1];
    assign xfer_req = !idx.tdis &&
                      ((play_pend && xcfg.play_en && !xcfg.play_pio) ||
                       (cap_pend  && xcfg.cap_en  && !xcfg.cap_pio));

    // R3: no register changes on a data write during initialization
    a_r3_init_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_we && port == PORT_DATA && init_busy) |=> $stable(regs));

    // R11: pin disabled means no interrupt output
    a_r11_pin_gate: assert property (@(posedge clk) disable iff (rst)
        !regs[IX_PINCTL][1] |-> !irq_out);
endmodule

// File: tb/codec_rf_top_tb.sv
module codec_rf_top_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       init_busy = 1'b0;
    logic       sample_stb = 1'b0;
    logic [6:0] dp_flags = 7'd0;
    logic       play_pend = 1'b0;
    logic       cap_pend = 1'b0;
    logic       irq_out;
    logic       xfer_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0]  m_reg [16];
    logic        m_mce, m_tdis, m_int;
    logic [3:0]  m_sel;
    logic [15:0] m_cnt;

    codec_rf_top u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .init_busy(init_busy),
        .sample_stb(sample_stb), .dp_flags(dp_flags), .play_pend(play_pend),
        .cap_pend(cap_pend), .irq_out(irq_out), .xfer_req(xfer_req)
    );

    initial forever #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] exp_reset(int ix);
        if (ix >= 2 && ix <= 7) return 8'h80;
        if (ix == 9)  return 8'h10;
        if (ix == 12) return 8'h08;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_mask(int ix, logic mce);
        if (ix == 8)  return mce ? 8'hFF : 8'h00;
        if (ix == 9)  return mce ? 8'hFF : 8'h03;
        if (ix == 12) return 8'hF0;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] exp_read(logic [1:0] a);
        case (a)
            2'd0: return {init_busy, m_mce, m_tdis, 1'b0, m_sel};
            2'd1: return init_busy ? 8'h80 : m_reg[m_sel];
            2'd2: return {dp_flags, m_int};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_xfer();
        return !m_tdis && ((play_pend && m_reg[9][0] && !m_reg[9][6]) ||
                           (cap_pend && m_reg[9][1] && !m_reg[9][7]));
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = exp_reset(i);
        m_mce = 1'b1; m_tdis = 1'b0; m_sel = 4'd0; m_int = 1'b0; m_cnt = 16'd0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        logic [7:0] mk;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        case (a)
            2'd0: begin m_mce = d[6]; m_tdis = d[5]; m_sel = d[3:0]; end
            2'd1: if (!init_busy) begin
                mk = exp_mask(m_sel, m_mce);
                if (m_sel == 4'd14) m_cnt = {d, m_reg[15]};
                m_reg[m_sel] = (m_reg[m_sel] & ~mk) | (d & mk);
            end
            2'd2: m_int = 1'b0;
            default: ;
        endcase
        @(posedge clk); #1 bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check_read(input logic [1:0] a, input string req);
        logic [7:0] d;
        bus_read(a, d);
        check(d === exp_read(a), req, {8'h0, d}, {8'h0, exp_read(a)});
    endtask

    task automatic pulse_strobe();
        @(negedge clk);
        sample_stb = 1'b1;
        if ((m_reg[9][0] || m_reg[9][1]) && !m_mce) begin
            if (m_cnt == 16'd0) begin m_int = 1'b1; m_cnt = {m_reg[14], m_reg[15]}; end
            else m_cnt = m_cnt - 16'd1;
        end
        @(posedge clk); #1 sample_stb = 1'b0;
    endtask

    task automatic write_ix(input logic [3:0] ix, input logic [7:0] d);
        bus_write(2'd0, {1'b0, m_mce, m_tdis, 1'b0, ix});
        bus_write(2'd1, d);
    endtask

    task automatic check_pins(input string req);
        #1;
        check(irq_out === (m_int && m_reg[10][1]), req, {15'h0, irq_out}, {15'h0, m_int && m_reg[10][1]});
        check(xfer_req === exp_xfer(), "R12", {15'h0, xfer_req}, {15'h0, exp_xfer()});
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h00C0_DEC5));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state of every register and the index port
        check_read(2'd0, "R1");
        check_read(2'd3, "R1");
        for (int i = 0; i < 16; i++) begin
            bus_write(2'd0, {4'b0100, 4'(i)});
            check_read(2'd1, "R1");
        end
        bus_write(2'd3, 8'hFF);
        check_read(2'd3, "R1");

        // R2: index layout, reserved bit reads 0
        bus_write(2'd0, 8'hFF);
        check_read(2'd0, "R2");
        init_busy = 1'b1;
        check_read(2'd0, "R2");

        // R3: writes blocked and 80h read during init
        bus_write(2'd0, 8'h43);
        bus_write(2'd1, 8'h5A);
        check_read(2'd1, "R3");
        init_busy = 1'b0;
        check_read(2'd1, "R3");

        // R4, R5, R6: locks
        bus_write(2'd0, 8'h08);
        bus_write(2'd1, 8'h7E);
        check_read(2'd1, "R4");
        bus_write(2'd0, 8'h48);
        bus_write(2'd1, 8'h7E);
        check_read(2'd1, "R4");
        bus_write(2'd0, 8'h09);
        bus_write(2'd1, 8'hFC);
        check_read(2'd1, "R5");
        bus_write(2'd1, 8'h03);
        check_read(2'd1, "R5");
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h0C);
        bus_write(2'd1, 8'hA1);
        check_read(2'd1, "R6");

        // R7/R8: base 3, playback enabled, interrupt on strobe 4
        m_mce = 1'b0;
        write_ix(4'd15, 8'h03);
        write_ix(4'd14, 8'h00);
        write_ix(4'd9, 8'h01);
        for (int s = 1; s <= 4; s++) begin
            pulse_strobe();
            bus_read(2'd2, d);
            check(d[0] === (s == 4), "R8", {15'h0, d[0]}, {15'h0, s == 4});
        end
        // R11: pin gated
        check_pins("R11");
        write_ix(4'd10, 8'h02);
        check_pins("R11");
        check(irq_out === 1'b1, "R11", {15'h0, irq_out}, 16'h1);
        // R10: status write clears
        dp_flags = 7'h55;
        bus_write(2'd2, 8'h00);
        check_read(2'd2, "R10");
        // R8: period repeats after reload
        for (int s = 1; s <= 4; s++) pulse_strobe();
        check_read(2'd2, "R8");
        check(m_int === 1'b1, "R8", {15'h0, m_int}, 16'h1);
        bus_write(2'd2, 8'h00);
        // R7: low write alone does not reload
        write_ix(4'd15, 8'h00);
        for (int s = 1; s <= 3; s++) pulse_strobe();
        check_read(2'd2, "R7");
        pulse_strobe();
        check_read(2'd2, "R7");
        bus_write(2'd2, 8'h00);
        // R8: enables clear, strobes ignored
        write_ix(4'd9, 8'h00);
        for (int s = 0; s < 6; s++) pulse_strobe();
        check_read(2'd2, "R8");
        // R9: mode change freezes counter
        write_ix(4'd9, 8'h02);
        write_ix(4'd14, 8'h00);
        bus_write(2'd0, 8'h40);
        for (int s = 0; s < 3; s++) pulse_strobe();
        check_read(2'd2, "R9");
        bus_write(2'd0, 8'h00);
        pulse_strobe();
        check_read(2'd2, "R9");
        bus_write(2'd2, 8'h00);

        // R12: directed transfer request
        play_pend = 1'b1;
        write_ix(4'd9, 8'h01);
        check_pins("R12");
        bus_write(2'd0, 8'h20);
        check_pins("R12");
        bus_write(2'd0, 8'h49);
        bus_write(2'd1, 8'h41);
        check_pins("R12");
        play_pend = 1'b0;

        // Random mixed traffic
        for (int n = 0; n < 1500; n++) begin
            int op;
            op = $urandom % 9;
            play_pend = 1'($urandom);
            cap_pend = 1'($urandom);
            dp_flags = 7'($urandom);
            case (op)
                0: bus_write(2'd0, 8'($urandom));
                1, 2: bus_write(2'd1, 8'($urandom));
                3: check_read(2'd1, "R3");
                4, 8: pulse_strobe();
                5: check_read(2'd2, "R10");
                6: if ($urandom % 4 == 0) bus_write(2'd2, 8'($urandom));
                7: begin
                    if ($urandom % 3 == 0) init_busy = ~init_busy;
                    check_read(2'd0, "R2");
                end
                default: ;
            endcase
            check_pins("R11");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule